// File: doc/BRIEF.md
# Pseudo Dual-Issue Group Counter

This block watches a stream of instructions that a core issues one at a time. It estimates how many issue groups the same stream would need on a wider machine that can pair some functional units in one cycle. Each incoming instruction carries a functional-unit class and a dependency flag. The block keeps an issue credit for each class. It opens a new group when the current group has no room for the instruction's class, or when the instruction depends on an earlier one.

Every new group adds one to a 32-bit group count and raises a one-cycle pulse. A second 32-bit counter counts every valid instruction, so the ratio between the two counts can be read off. Instruction decode and dependency detection happen upstream and are not part of this block.

Top module: `grp_issue_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `groupCount` and `instCount` are zero and `newGroup` is low.
- R2: All class credits are zero after reset, so the first valid instruction always opens a group.
- R3: A valid instruction with `depFlag` high opens a new group, even when its class still has credit left.
- R4: Arithmetic (code 1), load (code 4) and store (code 5) may each appear twice in one group. A third instruction of the same class opens a new group.
- R5: Every other class may appear only once per group: unknown (0), shift (2), compare (3), move-immediate (6), jump (7), branch (8) and no-op (9). A second instruction of the same class opens a new group.
- R6: Instructions of different classes share one group as long as each class has credit left.
- R7: A valid instruction that opens a group raises `newGroup` for exactly one cycle, in the cycle after it is presented. In that same cycle `groupCount` has gone up by exactly one. Otherwise `groupCount` holds its value.
- R8: Cycles with `instValid` low change no credit and no counter, whatever `unitClass` and `depFlag` hold.
- R9: `instCount` goes up by one, one cycle after each valid instruction.
- R10: Class codes 10 to 15 are counted as the unknown class (code 0) and share its single credit.
- R11: When a group opens, every credit is reloaded first, and then the credit of the instruction that opened it is used up. Two more arithmetic instructions after the opener therefore fit as follows: the next one fits, and the one after it opens a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction is presented this cycle |
| unitClass | input | 4 | Functional-unit class code of the instruction |
| depFlag | input | 1 | The instruction depends on an earlier one |
| groupCount | output | 32 | Number of issue groups opened since reset |
| instCount | output | 32 | Number of valid instructions since reset |
| newGroup | output | 1 | One-cycle pulse: the last instruction opened a group |

## Verification
If a credit is wrong, the error stays hidden until the next instruction of that class arrives. At that point `newGroup` either fires or fails to fire one cycle later, and `groupCount` moves away from the expected total for good. The directed sequences therefore always follow a class with a second and third instruction of the same class. This exposes a wrong reload value, a missing decrement or an idle cycle that leaks into the credits within three instructions. Remapped codes are checked by the same method, by following them with a true unknown-class instruction.

// File: rtl/grp_cnt_pkg.sv
package grp_cnt_pkg;
  localparam int NUM_CLASS = 10;
  localparam int CLASS_W   = 4;
  localparam int CREDIT_W  = 2;
  localparam int PAIR_CREDIT = 2;

  typedef enum logic [CLASS_W-1:0] {
    UC_UNKNOWN = 4'd0,
    UC_ARITH   = 4'd1,
    UC_SHIFT   = 4'd2,
    UC_COMPARE = 4'd3,
    UC_LOAD    = 4'd4,
    UC_STORE   = 4'd5,
    UC_MOVIMM  = 4'd6,
    UC_JUMP    = 4'd7,
    UC_BRANCH  = 4'd8,
    UC_NOP     = 4'd9
  } unit_class_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic               take;  // valid instruction this cycle
    logic               open;  // it starts a new group
    logic [CLASS_W-1:0] slot;  // credit slot it consumes
  } grp_strobe_t;

  // Reload value of one class credit at the start of a group
  function automatic logic [CREDIT_W-1:0] reloadCredit(input int idx);
    if (idx == int'(UC_ARITH) || idx == int'(UC_LOAD) || idx == int'(UC_STORE))
      return CREDIT_W'(PAIR_CREDIT);
    return CREDIT_W'(1);
  endfunction
endpackage

// File: rtl/grp_cnt_ctrl.sv
module grp_cnt_ctrl
  import grp_cnt_pkg::*;
#(
  parameter int NCLS = NUM_CLASS,
  parameter int CW   = CLASS_W
) (
  input  logic            instValid,
  input  logic [CW-1:0]   unitClass,
  input  logic            depFlag,
  input  logic [NCLS-1:0] creditEmpty,
  output grp_strobe_t     strobe
);
  logic [CW-1:0] slot;
  logic          emptySel;

  // Codes outside the class range fold onto the unknown class
  assign slot = (unitClass < CW'(NCLS)) ? unitClass : CW'(UC_UNKNOWN);

  always_comb begin
    emptySel = 1'b0;
    for (int i = 0; i < NCLS; i++) begin
      if (slot == CW'(i)) emptySel = creditEmpty[i];
    end
  end

  always_comb begin
    strobe.take = instValid;
    strobe.open = instValid && (depFlag || emptySel);
    strobe.slot = slot;
  end
endmodule

// File: rtl/grp_cnt_dp.sv
module grp_cnt_dp
  import grp_cnt_pkg::*;
#(
  parameter int NCLS = NUM_CLASS,
  parameter int CW   = CLASS_W,
  parameter int KW   = CREDIT_W,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  grp_strobe_t      strobe,
  output logic [NCLS-1:0]  creditEmpty,
  output logic [CNT_W-1:0] groupCount,
  output logic [CNT_W-1:0] instCount,
  output logic             newGroup
);
  genvar g;
  generate
    for (g = 0; g < NCLS; g++) begin : g_credit
      localparam logic [KW-1:0] RELOAD = reloadCredit(g);
      logic [KW-1:0] credit;
      always_ff @(posedge clk) begin
        if (rst) begin
          credit <= '0;
        end else if (strobe.take) begin
          if (strobe.open)
            credit <= (strobe.slot == CW'(g)) ? RELOAD - KW'(1) : RELOAD;
          else if (strobe.slot == CW'(g))
            credit <= credit - KW'(1);
        end
      end
      assign creditEmpty[g] = (credit == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      groupCount <= '0;
      instCount  <= '0;
      newGroup   <= 1'b0;
    end else begin
      newGroup <= strobe.open;
      if (strobe.take) instCount  <= instCount + CNT_W'(1);
      if (strobe.open) groupCount <= groupCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/grp_issue_counter.sv
module grp_issue_counter
  import grp_cnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instValid,
  input  logic [CLASS_W-1:0] unitClass,
  input  logic               depFlag,
  output logic [CNT_W-1:0]   groupCount,
  output logic [CNT_W-1:0]   instCount,
  output logic               newGroup
);
  grp_strobe_t          strobe;
  logic [NUM_CLASS-1:0] creditEmpty;

  grp_cnt_ctrl #(.NCLS(NUM_CLASS), .CW(CLASS_W)) u_ctrl (
    .instValid  (instValid),
    .unitClass  (unitClass),
    .depFlag    (depFlag),
    .creditEmpty(creditEmpty),
    .strobe     (strobe)
  );

  grp_cnt_dp #(.NCLS(NUM_CLASS), .CW(CLASS_W), .KW(CREDIT_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .creditEmpty(creditEmpty),
    .groupCount (groupCount),
    .instCount  (instCount),
    .newGroup   (newGroup)
  );
endmodule

// File: rtl/grp_issue_counter_chk.sv
module grp_issue_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             instValid,
  input logic [3:0]       unitClass,
  input logic             depFlag,
  input logic [CNT_W-1:0] groupCount,
  input logic [CNT_W-1:0] instCount,
  input logic             newGroup
);
  // R3
  dep_opens_chk: assert property (@(posedge clk) disable iff (rst)
    instValid && depFlag |=> newGroup);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> !newGroup && $stable(instCount) && $stable(groupCount));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    newGroup |-> groupCount == $past(groupCount) + CNT_W'(1));

  // R9
  inst_step_chk: assert property (@(posedge clk) disable iff (rst)
    instValid |=> instCount == $past(instCount) + CNT_W'(1));

  // R5
  single_shift_chk: assert property (@(posedge clk) disable iff (rst)
    instValid && unitClass == 4'd2 ##1 instValid && unitClass == 4'd2 |=> newGroup);
endmodule

bind grp_issue_counter grp_issue_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/grp_issue_counter_bench.sv
module grp_issue_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [3:0]  unitClass = 4'd0;
  logic        depFlag = 1'b0;
  logic [31:0] groupCount, instCount;
  logic        newGroup;

  int checks = 0;
  int errors = 0;
  int expGroups = 0;
  int expInsts = 0;
  bit finished = 1'b0;

  localparam logic [3:0] C_UNK = 4'd0, C_ARI = 4'd1, C_SHF = 4'd2, C_CMP = 4'd3,
    C_LD = 4'd4, C_ST = 4'd5, C_MOV = 4'd6, C_JMP = 4'd7, C_BR = 4'd8, C_NOP = 4'd9;

  always #4 clk = ~clk;

  grp_issue_counter u_grp_issue_counter (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; instValid = 1'b0; depFlag = 1'b0; unitClass = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    expGroups = 0; expInsts = 0;
  endtask

  // Present one cycle of input, then check outputs one cycle later
  task automatic step(input bit v, input logic [3:0] c, input bit d,
                      input bit expOpen, input string tag);
    instValid = v; unitClass = c; depFlag = d;
    @(negedge clk);
    if (expOpen) expGroups++;
    if (v) expInsts++;
    check({tag, " newGroup"}, int'(newGroup), int'(expOpen));
    check({tag, " groupCount"}, int'(groupCount), expGroups);
    check({tag, " instCount"}, int'(instCount), expInsts);
    instValid = 1'b0; depFlag = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 in-reset groupCount", int'(groupCount), 0);
    check("R1 in-reset newGroup", int'(newGroup), 0);
    rst = 1'b0; instValid = 1'b0;
    @(negedge clk);
    check("R1 groupCount", int'(groupCount), 0);
    check("R1 instCount", int'(instCount), 0);
    check("R1 newGroup", int'(newGroup), 0);
  endtask

  task automatic testFirst();
    doReset();
    step(1, C_NOP, 0, 1, "R2 first");
    step(0, C_NOP, 0, 0, "R7 pulse drops");
  endtask

  task automatic testPairs();
    doReset();
    step(1, C_ARI, 0, 1, "R4 ari1");
    step(1, C_ARI, 0, 0, "R4 ari2");
    step(1, C_ARI, 0, 1, "R4 ari3");
    step(1, C_ARI, 0, 0, "R11 ari4");
    step(1, C_ARI, 0, 1, "R11 ari5");
    doReset();
    step(1, C_LD, 0, 1, "R4 ld1");
    step(1, C_LD, 0, 0, "R4 ld2");
    step(1, C_LD, 0, 1, "R4 ld3");
    doReset();
    step(1, C_ST, 0, 1, "R4 st1");
    step(1, C_ST, 0, 0, "R4 st2");
    step(1, C_ST, 0, 1, "R4 st3");
  endtask

  task automatic testSingles();
    logic [3:0] cls [7] = '{C_UNK, C_SHF, C_CMP, C_MOV, C_JMP, C_BR, C_NOP};
    doReset();
    for (int i = 0; i < 7; i++) begin
      step(1, cls[i], 0, i == 0, "R5 single first");
      step(1, cls[i], 0, 1, "R5 single second");
    end
  endtask

  task automatic testMixed();
    logic [3:0] seq [13] = '{C_ARI, C_SHF, C_LD, C_CMP, C_ST, C_BR, C_MOV,
                             C_JMP, C_NOP, C_UNK, C_ARI, C_LD, C_ST};
    doReset();
    for (int i = 0; i < 13; i++) step(1, seq[i], 0, i == 0, "R6 mixed");
    check("R9 mixed instCount", int'(instCount), 13);
  endtask

  task automatic testDep();
    doReset();
    step(1, C_ARI, 0, 1, "R3 base");
    step(1, C_ARI, 1, 1, "R3 dep with credit");
    step(1, C_ARI, 0, 0, "R3 after dep");
    step(1, C_SHF, 1, 1, "R3 dep other class");
  endtask

  task automatic testIdle();
    doReset();
    step(1, C_ARI, 0, 1, "R8 base");
    step(0, C_ARI, 1, 0, "R8 idle1");
    step(0, C_SHF, 1, 0, "R8 idle2");
    step(0, C_ARI, 0, 0, "R8 idle3");
    step(1, C_SHF, 0, 0, "R8 shift credit kept");
    step(1, C_ARI, 0, 0, "R8 ari credit kept");
    step(1, C_ARI, 0, 1, "R8 ari exhausted");
  endtask

  task automatic testRemap();
    doReset();
    step(1, 4'd12, 0, 1, "R10 code12");
    step(1, C_UNK, 0, 1, "R10 unknown after 12");
    step(1, 4'd15, 0, 1, "R10 code15 after unknown");
    step(1, C_NOP, 0, 0, "R10 nop distinct");
    step(1, 4'd10, 0, 1, "R10 code10");
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testFirst();
    testPairs();
    testSingles();
    testMixed();
    testDep();
    testIdle();
    testRemap();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule